// File: doc/BRIEF.md
# Serial Keyboard Matrix Encoder

This block scans a matrix of key switches and reports each press as a short serial code on one active-low data line. It drives one column at a time and examines one row per clock. A 5-bit scan position walks through all 32 key sites. When the examined site reads pressed, the position freezes and names the key.

Command keys report a 7-bit code built from their position. A parameter mask marks some command positions as deferred. A deferred code is held back and sent just before the code of the next command key.

Number keys use a two-step exchange. First, a generic "number pressed" code goes out. There are two versions of this code, and the one used depends on whether the decimal-point key has been seen since the last clear. The block then parks until a downstream controller pulls the figure strobe low for four clocks. During those four clocks, the key's BCD value is shifted out.

Top module: `kbd_serial_encoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `key_data_n` is 1 and `col_drv` is `4'b0001` (scan position 0).
- R2: With no key pressed and `busy` low, the scan position advances by one each clock from 0 after reset. Exactly one column is driven, and it is column `pos[4:3]`. The row examined is `pos[2:0]`, so each column is driven for 8 consecutive clocks, in ascending order.
- R3: A command key at scan position p sends the code `{p, 2'b01}` serially. The code goes out least significant bit first, one bit per clock, inverted on `key_data_n`, with idle level 1. Two codes queued together are sent back to back.
- R4: Positions 0 to 9 are number keys and send code `7'h03`, or `7'h07` once the decimal-point key (position 10) has been pressed since the last reset. The decimal-point key always sends its own command code at once.
- R5: After a number code, each clock in which `fig_req_n` is low, up to four clocks, presents the next bit of the key's BCD value (equal to p), LSB first, inverted on `key_data_n` in that same cycle.
- R6: While parked waiting for the figure strobe, the scanner is stopped, and further presses produce no code. The digit later sent is the one that caused the park.
- R7: A key whose `DEFER_MASK` bit is set sends nothing when pressed and becomes pending. The next command key first sends the pending code. If that key is immediate, its own code follows; if it is deferred, it becomes the new pending code.
- R8: While `busy` is high, no new code is started and the scan position holds. A key found after `busy` falls is reported normally.
- R9: After a key is handled, all columns are driven (`col_drv` all ones), and scanning resumes from position 0 only once every row reads idle. A held key is therefore reported exactly once.
- R10: Reset discards a pending deferred code, the decimal-point history and a parked digit, and restarts scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| row_sense | input | ROWS | Row sense lines, 1 = a key joins this row to a driven column |
| busy | input | 1 | Downstream busy, 1 = hold off new codes |
| fig_req_n | input | 1 | Figure strobe, active low, four clocks wide |
| col_drv | output | COLS | Column drive, one-hot while scanning, all ones while waiting for release |
| key_data_n | output | 1 | Serial key data, active low, LSB first |

## Verification
The bench builds the block with the default 4 by 8 matrix and a deferral mask of `32'h8030_0000`, which makes positions 20, 21 and 31 deferred. With three deferred sites, runs of deferred keys can chain, so one pending code is replaced by another while a single frame goes out. A deferred code can also be flushed by an immediate command, which sends a 14-bit back-to-back pair. The decimal-point key at position 10 sits next to the digit keys, so random sequences switch the number code between its two forms.

// File: rtl/kse_pkg.sv
package kse_pkg;

    localparam int KSE_BCD_W = 4;

    typedef enum logic [1:0] {
        ST_SCAN,
        ST_SEND,
        ST_FIG,
        ST_RELEASE
    } kse_state_e;

    typedef enum logic [1:0] {
        KEY_DIGIT,
        KEY_POINT,
        KEY_CMD_NOW,
        KEY_CMD_LATER
    } key_kind_e;

    typedef struct packed {
        key_kind_e              kind;
        logic [KSE_BCD_W-1:0]   digit;
    } key_info_t;

    function automatic logic sends_at_once(input key_kind_e kind);
        return (kind == KEY_POINT) || (kind == KEY_CMD_NOW);
    endfunction

endpackage

// File: rtl/kse_scan.sv
module kse_scan #(
    parameter int COLS = 4,
    parameter int ROWS = 8
)(
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   run,
    input  logic                                   restart,
    input  logic                                   all_cols,
    input  logic [ROWS-1:0]                        row_sense,
    output logic [COLS-1:0]                        col_drv,
    output logic [$clog2(COLS)+$clog2(ROWS)-1:0]   pos,
    output logic                                   hit
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int POS_W = COL_W + ROW_W;
    localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

    logic [POS_W-1:0] pos_q;
    logic [COL_W-1:0] col_idx;
    logic [ROW_W-1:0] row_idx;

    assign col_idx = pos_q[POS_W-1:ROW_W];
    assign row_idx = pos_q[ROW_W-1:0];
    assign pos     = pos_q;
    assign hit     = run && row_sense[row_idx];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_drv[c] = all_cols || (col_idx == COL_W'(c));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos_q <= '0;
        end else if (run && !hit) begin
            pos_q <= pos_q + POS_ONE;
        end
    end

    // R8: position frozen whenever scanning is not enabled
    p_scan_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(pos_q))
        else $error("scan position moved while stopped");

    // R2: a found key stops the walk
    p_hit_stops_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && !restart) |=> (pos_q == $past(pos_q)))
        else $error("scan moved past a pressed key");

endmodule

// File: rtl/kse_keymap.sv
module kse_keymap
    import kse_pkg::*;
#(
    parameter int                    COLS           = 4,
    parameter int                    ROWS           = 8,
    parameter int                    DIGITS         = 10,
    parameter int                    POINT_POS      = 10,
    parameter logic [COLS*ROWS-1:0]  DEFER_MASK     = 32'h000F_0000,
    parameter int                    NUM_CODE_PLAIN = 7'h03,
    parameter int                    NUM_CODE_FRAC  = 7'h07
)(
    input  logic [$clog2(COLS)+$clog2(ROWS)-1:0]   pos,
    input  logic                                   point_seen,
    output key_info_t                              info,
    output logic [$clog2(COLS)+$clog2(ROWS)+1:0]   code
);
    localparam int POS_W  = $clog2(COLS) + $clog2(ROWS);
    localparam int CODE_W = POS_W + 2;

    always_comb begin
        info.digit = KSE_BCD_W'(pos);
        if (pos < POS_W'(DIGITS)) begin
            info.kind = KEY_DIGIT;
        end else if (pos == POS_W'(POINT_POS)) begin
            info.kind = KEY_POINT;
        end else if (DEFER_MASK[pos]) begin
            info.kind = KEY_CMD_LATER;
        end else begin
            info.kind = KEY_CMD_NOW;
        end

        if (info.kind == KEY_DIGIT) begin
            code = point_seen ? CODE_W'(NUM_CODE_FRAC) : CODE_W'(NUM_CODE_PLAIN);
        end else begin
            code = {pos, 2'b01};
        end
    end

    // R3: every emitted code has its start bit set
    always_comb begin
        p_code_start_r3: assert (code[0] == 1'b1)
            else $error("code without start bit");
    end

endmodule

// File: rtl/kse_tx.sv
module kse_tx #(
    parameter int CODE_W = 7
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    input  logic              two,
    output logic              ser_bit,
    output logic              active
);
    localparam int SH_W  = 2 * CODE_W;
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] left_q;

    assign active  = (left_q != '0);
    assign ser_bit = active && sh_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= two ? {code_b, code_a} : {{CODE_W{1'b0}}, code_a};
            left_q <= two ? CNT_W'(SH_W) : CNT_W'(CODE_W);
        end else if (active) begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - CNT_ONE;
        end
    end

    // R3: each frame handed over starts with a set bit
    p_frame_start_r3: assert property (@(posedge clk) disable iff (rst)
        load |-> (code_a[0] && (!two || code_b[0])))
        else $error("frame without start bit");

    // R3: no new frame while one is on the wire
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        active |-> !load)
        else $error("frame loaded over a running frame");

endmodule

// File: rtl/kbd_serial_encoder.sv
module kbd_serial_encoder
    import kse_pkg::*;
#(
    parameter int                    COLS           = 4,
    parameter int                    ROWS           = 8,
    parameter int                    DIGITS         = 10,
    parameter int                    POINT_POS      = 10,
    parameter logic [COLS*ROWS-1:0]  DEFER_MASK     = 32'h000F_0000,
    parameter int                    NUM_CODE_PLAIN = 7'h03,
    parameter int                    NUM_CODE_FRAC  = 7'h07
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [ROWS-1:0]  row_sense,
    input  logic             busy,
    input  logic             fig_req_n,
    output logic [COLS-1:0]  col_drv,
    output logic             key_data_n
);
    localparam int POS_W  = $clog2(COLS) + $clog2(ROWS);
    localparam int CODE_W = POS_W + 2;
    localparam int FC_W   = $clog2(KSE_BCD_W);
    localparam logic [FC_W-1:0] FIG_LAST = FC_W'(KSE_BCD_W - 1);
    localparam logic [FC_W-1:0] FC_ONE   = FC_W'(1);

    kse_state_e             state_q, after_q;
    logic                   point_q;
    logic                   pend_v_q;
    logic [CODE_W-1:0]      pend_code_q;
    logic [KSE_BCD_W-1:0]   digit_q;
    logic [FC_W-1:0]        fig_cnt_q;

    logic                   run, restart, all_cols, hit;
    logic [POS_W-1:0]       pos;
    key_info_t              info;
    logic [CODE_W-1:0]      code;
    logic                   tx_load, tx_two, tx_bit, tx_active;
    logic [CODE_W-1:0]      tx_a, tx_b;

    assign run      = (state_q == ST_SCAN) && !busy;
    assign all_cols = (state_q == ST_RELEASE);
    assign restart  = (state_q == ST_RELEASE) && (row_sense == '0);

    kse_scan #(.COLS(COLS), .ROWS(ROWS)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .restart   (restart),
        .all_cols  (all_cols),
        .row_sense (row_sense),
        .col_drv   (col_drv),
        .pos       (pos),
        .hit       (hit)
    );

    kse_keymap #(
        .COLS           (COLS),
        .ROWS           (ROWS),
        .DIGITS         (DIGITS),
        .POINT_POS      (POINT_POS),
        .DEFER_MASK     (DEFER_MASK),
        .NUM_CODE_PLAIN (NUM_CODE_PLAIN),
        .NUM_CODE_FRAC  (NUM_CODE_FRAC)
    ) u_keymap (
        .pos        (pos),
        .point_seen (point_q),
        .info       (info),
        .code       (code)
    );

    // frame request formed from the key found this cycle
    always_comb begin
        tx_load = 1'b0;
        tx_two  = 1'b0;
        tx_a    = code;
        tx_b    = code;
        if (state_q == ST_SCAN && hit) begin
            unique case (info.kind)
                KEY_DIGIT: begin
                    tx_load = 1'b1;
                end
                KEY_POINT, KEY_CMD_NOW: begin
                    tx_load = 1'b1;
                    if (pend_v_q) begin
                        tx_a   = pend_code_q;
                        tx_two = 1'b1;
                    end
                end
                KEY_CMD_LATER: begin
                    tx_load = pend_v_q;
                    tx_a    = pend_code_q;
                end
            endcase
        end
    end

    kse_tx #(.CODE_W(CODE_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (tx_load),
        .code_a  (tx_a),
        .code_b  (tx_b),
        .two     (tx_two),
        .ser_bit (tx_bit),
        .active  (tx_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_SCAN;
            after_q     <= ST_RELEASE;
            point_q     <= 1'b0;
            pend_v_q    <= 1'b0;
            pend_code_q <= '0;
            digit_q     <= '0;
            fig_cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_SCAN: begin
                    if (hit) begin
                        digit_q <= info.digit;
                        after_q <= ST_RELEASE;
                        unique case (info.kind)
                            KEY_DIGIT: begin
                                after_q <= ST_FIG;
                                state_q <= ST_SEND;
                            end
                            KEY_POINT, KEY_CMD_NOW: begin
                                point_q  <= point_q || (info.kind == KEY_POINT);
                                pend_v_q <= 1'b0;
                                state_q  <= ST_SEND;
                            end
                            KEY_CMD_LATER: begin
                                pend_code_q <= code;
                                pend_v_q    <= 1'b1;
                                state_q     <= pend_v_q ? ST_SEND : ST_RELEASE;
                            end
                        endcase
                    end
                end
                ST_SEND: begin
                    if (!tx_active) begin
                        state_q <= after_q;
                    end
                end
                ST_FIG: begin
                    if (!fig_req_n) begin
                        fig_cnt_q <= fig_cnt_q + FC_ONE;
                        if (fig_cnt_q == FIG_LAST) begin
                            fig_cnt_q <= '0;
                            state_q   <= ST_RELEASE;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (row_sense == '0) begin
                        state_q <= ST_SCAN;
                    end
                end
            endcase
        end
    end

    always_comb begin
        if (state_q == ST_SEND) begin
            key_data_n = !tx_bit;
        end else if (state_q == ST_FIG && !fig_req_n) begin
            key_data_n = !digit_q[fig_cnt_q];
        end else begin
            key_data_n = 1'b1;
        end
    end

    // R2: a single column while the walk is running
    p_col_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN) |-> $onehot(col_drv))
        else $error("column drive not one-hot while scanning");

    // R3: line idles high when no frame is running and no strobe is served
    p_line_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !(state_q == ST_FIG && !fig_req_n)) |-> key_data_n)
        else $error("data line active with nothing to send");

    // R4: decimal-point history only cleared by reset
    p_point_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        point_q |=> point_q)
        else $error("decimal-point history lost");

    // R6: parked until the strobe arrives
    p_fig_park_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIG && fig_req_n) |=> (state_q == ST_FIG && !tx_active))
        else $error("left the figure wait without a strobe");

    // R8: nothing starts while downstream is busy
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && busy) |=> !tx_active)
        else $error("frame started while busy");

    // R9: stay in release while any row is still closed
    p_release_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELEASE && row_sense != '0) |=> (state_q == ST_RELEASE))
        else $error("scan resumed with a key still closed");

endmodule

// File: tb/kbd_serial_encoder_test.sv
`timescale 1ns/1ps
module kbd_serial_encoder_test;

    localparam logic [31:0] TB_MASK = 32'h8030_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  row_sense;
    logic        busy = 1'b0;
    logic        fig_req_n = 1'b1;
    logic [3:0]  col_drv;
    logic        key_data_n;
    logic [31:0] pressed = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    kbd_serial_encoder #(.DEFER_MASK(TB_MASK)) uut (
        .clk        (clk),
        .rst        (rst),
        .row_sense  (row_sense),
        .busy       (busy),
        .fig_req_n  (fig_req_n),
        .col_drv    (col_drv),
        .key_data_n (key_data_n)
    );

    // switch matrix model
    always_comb begin
        row_sense = '0;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 8; r++) begin
                if (col_drv[c] && pressed[c*8+r]) row_sense[r] = 1'b1;
            end
        end
    end

    // receiver: frames start on a set bit, strobe cycles collect the digit
    logic [6:0] frames [0:63];
    int         nframes = 0;
    logic [6:0] acc = '0;
    int         idx = 0;
    logic [3:0] figv = '0;
    int         fpos = 0;

    always @(negedge clk) begin
        if (rst) begin
            idx  = 0;
            fpos = 0;
        end else if (!fig_req_n) begin
            if (fpos < 4) figv[2'(fpos)] = ~key_data_n;
            fpos++;
        end else begin
            fpos = 0;
            if (idx == 0) begin
                if (!key_data_n) begin
                    acc    = 7'b0000001;
                    idx    = 1;
                end
            end else begin
                acc[3'(idx)] = ~key_data_n;
                idx++;
                if (idx == 7) begin
                    frames[6'(nframes)] = acc;
                    nframes++;
                    idx = 0;
                end
            end
        end
    end

    // reference model state
    bit         m_point = 1'b0;
    bit         m_pend_v = 1'b0;
    logic [6:0] m_pend = '0;

    function automatic logic [6:0] cmd_code(input int p);
        return {5'(p), 2'b01};
    endfunction

    function automatic bit is_later(input int p);
        return (p > 10) && TB_MASK[5'(p)];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        pressed = '0;
        busy = 1'b0;
        fig_req_n = 1'b1;
        tick(3);
        m_point  = 1'b0;
        m_pend_v = 1'b0;
        rst = 1'b0;
    endtask

    task automatic strobe_digit(input int d, input string req);
        @(posedge clk); #1;
        fig_req_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        fig_req_n = 1'b1;
        check(req, int'(figv), d);
    endtask

    // press key p, check the frames it yields, serve a digit, release
    task automatic key_op(input int p);
        int base;
        int nexp;
        logic [6:0] e0, e1;
        string tag;
        base = nframes;
        nexp = 0; e0 = '0; e1 = '0;
        if (p < 10) begin
            tag = "R4"; nexp = 1; e0 = m_point ? 7'h07 : 7'h03;
        end else if (!is_later(p)) begin
            tag = m_pend_v ? "R7" : "R3";
            if (m_pend_v) begin nexp = 2; e0 = m_pend; e1 = cmd_code(p); end
            else begin nexp = 1; e0 = cmd_code(p); end
            m_pend_v = 1'b0;
            if (p == 10) m_point = 1'b1;
        end else begin
            tag = "R7";
            if (m_pend_v) begin nexp = 1; e0 = m_pend; end
            m_pend = cmd_code(p);
            m_pend_v = 1'b1;
        end
        pressed[5'(p)] = 1'b1;
        tick(80);
        check(tag, nframes - base, nexp);
        if (nexp > 0) check(tag, int'(frames[6'(base)]), int'(e0));
        if (nexp > 1) check(tag, int'(frames[6'(base+1)]), int'(e1));
        if (p < 10) strobe_digit(p, "R5");
        pressed = '0;
        tick(10);
    endtask

    initial begin
        int base;
        int bad;
        void'($urandom(32'd20240611));

        // R1: reset state
        rst = 1'b1;
        tick(3);
        check("R1", int'(key_data_n), 1);
        check("R1", int'(col_drv), 1);
        rst = 1'b0;

        // R2: walk order after reset
        bad = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (col_drv != (4'b0001 << ((k / 8) % 4))) bad++;
        end
        check("R2", bad, 0);
        tick(1);

        // R3: immediate command codes
        key_op(25);
        key_op(11);

        // R4 / R5: digits before and after the decimal point
        key_op(7);
        key_op(0);
        key_op(10);
        key_op(3);
        key_op(9);

        // R6: parked digit ignores further presses
        do_reset();
        base = nframes;
        pressed[5] = 1'b1;
        tick(80);
        check("R6", nframes - base, 1);
        check("R6", int'(frames[6'(base)]), 3);
        pressed[26] = 1'b1;
        pressed[2]  = 1'b1;
        tick(120);
        check("R6", nframes - base, 1);
        check("R6", int'(key_data_n), 1);
        strobe_digit(5, "R6");
        pressed = '0;
        tick(10);

        // R7: deferred chains and flushes
        key_op(20);
        key_op(25);
        key_op(20);
        key_op(21);
        key_op(31);
        key_op(12);
        key_op(21);
        key_op(4);
        key_op(10);

        // R8: busy holds off codes
        busy = 1'b1;
        base = nframes;
        pressed[25] = 1'b1;
        tick(100);
        check("R8", nframes - base, 0);
        busy = 1'b0;
        tick(80);
        check("R8", nframes - base, 1);
        check("R8", int'(frames[6'(base)]), int'(cmd_code(25)));
        pressed = '0;
        tick(10);

        // R9: held key reported once, all columns driven meanwhile
        base = nframes;
        pressed[14] = 1'b1;
        tick(300);
        check("R9", nframes - base, 1);
        check("R9", int'(col_drv), 15);
        pressed = '0;
        tick(10);
        pressed[14] = 1'b1;
        tick(80);
        check("R9", nframes - base, 2);
        pressed = '0;
        tick(10);

        // R10: reset drops pending code, point history and parked digit
        key_op(10);
        key_op(21);
        pressed[6] = 1'b1;
        tick(80);
        pressed = '0;
        do_reset();
        tick(5);
        key_op(4);
        key_op(25);

        // randomized sequences against the model
        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(3, 0) == 0) begin
                busy = 1'b1;
                tick(int'($urandom_range(40, 5)));
                busy = 1'b0;
            end
            key_op(int'($urandom_range(31, 0)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule